// File: doc/BRIEF.md
# Vectored Interrupt Controller

The controller collects a set of level-sensitive peripheral request lines and turns them into two processor request outputs: a fast request with no vector and a vectored normal request. Software configures, through a simple word-addressed register bus, which sources are enabled, which of the two classes each source belongs to, a priority level for each source, and a handler address for each source.

For vectored requests a priority encoder picks the winning pending source, lowest level number first and lowest source number within a level. The handler address of the winner is presented in the vector register. Reading the vector register acknowledges the interrupt. From then on, sources at that level or a less urgent level are held off until software writes the vector register to signal end of interrupt. A strictly more urgent source can still interrupt, so acknowledged levels nest. When nothing is pending, the vector register shows a programmable default address.

Top module: `vic_top`

## Requirements
- R1: After reset all enables and class bits are 0, the default address is 0, both request outputs are low and the vector register (word 6) reads 0.
- R2: A source whose enable bit (word 1, bit i) is 0 has no effect on either output, while the raw status word (word 0) always mirrors the request inputs.
- R3: A source with class bit 1 (word 2, bit i) drives only `fiq_o`, which is the OR of the enabled class-1 requests; word 3 reports those sources.
- R4: Word 4 reports the enabled class-0 sources that are requesting and not held off by an acknowledged level, and `irq_o` is high exactly when that word is nonzero.
- R5: Among eligible class-0 sources the lowest priority level (word 128+i, 4 bits, 0 most urgent) wins, and within a level the lowest source number wins.
- R6: The vector register reads the handler address (word 64+i) of the winning source, or the default address (word 5) when no source is eligible.
- R7: A read of the vector register while `irq_o` is high marks the winner's level active; while levels are active, only sources with a level strictly below the most urgent active level are eligible.
- R8: Any write to the vector register (data ignored) clears the most urgent active level.
- R9: A configuration write changes the outputs only after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 32 | Peripheral requests, active high, synchronous |
| bus_rd_i | input | 1 | Read strobe; a read of word 6 acknowledges |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word, combinational |
| fiq_o | output | 1 | Fast request to the processor |
| irq_o | output | 1 | Vectored request to the processor |

## Verification
The assertions take for granted that a read strobe and a write strobe are never raised together, and that the request inputs are already synchronous and only change between clock edges. The stimulus keeps to this by issuing at most one bus operation per cycle from a single task and by changing requests only on the falling edge, while a reference model in the bench tracks the active-level set so that acknowledges taken with nothing pending and end-of-interrupt writes with no active level are also exercised.

// File: rtl/vic_pkg.sv
package vic_pkg;

   localparam int unsigned BUS_AW    = 8;
   localparam int unsigned W_RAW     = 0;
   localparam int unsigned W_ENABLE  = 1;
   localparam int unsigned W_CLASS   = 2;
   localparam int unsigned W_FSTAT   = 3;
   localparam int unsigned W_NSTAT   = 4;
   localparam int unsigned W_DEFAULT = 5;
   localparam int unsigned W_VECTOR  = 6;
   localparam int unsigned HAND_BASE = 64;
   localparam int unsigned PRIO_BASE = 128;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
   import vic_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_i,
   input  logic [BUS_AW-1:0]             addr_i,
   input  logic [DATA_W-1:0]             wdata_i,
   output logic [N_SRC-1:0]              en_o,
   output logic [N_SRC-1:0]              cls_o,
   output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
   output logic [N_SRC-1:0][DATA_W-1:0]  hand_o,
   output logic [DATA_W-1:0]             dflt_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o   <= '0;
         cls_o  <= '0;
         dflt_o <= '0;
      end else if (wr_i) begin
         if (addr_i == BUS_AW'(W_ENABLE))  en_o   <= wdata_i[N_SRC-1:0];
         if (addr_i == BUS_AW'(W_CLASS))   cls_o  <= wdata_i[N_SRC-1:0];
         if (addr_i == BUS_AW'(W_DEFAULT)) dflt_o <= wdata_i;
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prio_o[i] <= '1;
            hand_o[i] <= '0;
         end else if (wr_i) begin
            if (addr_i == BUS_AW'(PRIO_BASE + i)) prio_o[i] <= wdata_i[PRIO_W-1:0];
            if (addr_i == BUS_AW'(HAND_BASE + i)) hand_o[i] <= wdata_i;
         end
      end
   end

endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = 5
) (
   input  logic [N_SRC-1:0]             elig_i,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic                         any_o,
   output logic [IDX_W-1:0]             idx_o,
   output logic [PRIO_W-1:0]            lvl_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      lvl_o = '1;
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (elig_i[i] && (!any_o || prio_i[i] < lvl_o)) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
            lvl_o = prio_i[i];
         end
      end
   end

endmodule

// File: rtl/vic_nest.sv
module vic_nest #(
   parameter int unsigned LVL_W  = 4,
   parameter int unsigned LEVELS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [LVL_W-1:0] push_lvl_i,
   input  logic             pop_i,
   output logic [LVL_W:0]   thr_o
);

   logic [LEVELS-1:0] active_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         active_q <= '0;
      else if (pop_i)
         active_q <= active_q & (active_q - 1'b1);
      else if (push_i)
         active_q[push_lvl_i] <= 1'b1;
   end

   always_comb begin
      thr_o = (LVL_W+1)'(LEVELS);
      for (int i = int'(LEVELS) - 1; i >= 0; i--)
         if (active_q[i]) thr_o = (LVL_W+1)'(i);
   end

   // R8: end of interrupt retires exactly one active level
   a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && active_q != '0) |=> $countones(active_q) == $past($countones(active_q)) - 1);

   // R8: end of interrupt with nothing active changes nothing
   a_r8_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && active_q == '0) |=> active_q == '0);

   // R7: an acknowledge leaves its level marked active
   a_r7_push_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |=> active_q[$past(push_lvl_i)]);

endmodule

// File: rtl/vic_top.sv
module vic_top
   import vic_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_req_i,
   input  logic              bus_rd_i,
   input  logic              bus_wr_i,
   input  logic [7:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              fiq_o,
   output logic              irq_o
);

   localparam int unsigned LEVELS = 2 ** PRIO_W;
   localparam int unsigned IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 1 || N_SRC > 64 || N_SRC > DATA_W) begin : g_bad_nsrc
      $error("vic_top: N_SRC must be 1..64 and fit in DATA_W");
   end
   if (PRIO_W < 1 || PRIO_W > 6 || PRIO_W > DATA_W) begin : g_bad_prio
      $error("vic_top: PRIO_W must be 1..6");
   end

   logic [N_SRC-1:0]             en, cls;
   logic [N_SRC-1:0][PRIO_W-1:0] prio;
   logic [N_SRC-1:0][DATA_W-1:0] hand;
   logic [DATA_W-1:0]            dflt;
   logic [N_SRC-1:0]             pend, fast, norm, elig;
   logic                         win_any;
   logic [IDX_W-1:0]             win_idx;
   logic [PRIO_W-1:0]            win_lvl;
   logic [PRIO_W:0]              thr;
   logic [DATA_W-1:0]            vector;
   logic                         vec_hit, ack, eoi;

   vic_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
      .wdata_i(bus_wdata_i), .en_o(en), .cls_o(cls), .prio_o(prio),
      .hand_o(hand), .dflt_o(dflt)
   );

   assign pend = src_req_i & en;
   assign fast = pend & cls;
   assign norm = pend & ~cls;

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      assign elig[i] = norm[i] && ({1'b0, prio[i]} < thr);
   end

   vic_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_arb (
      .elig_i(elig), .prio_i(prio), .any_o(win_any), .idx_o(win_idx), .lvl_o(win_lvl)
   );

   assign vec_hit = (bus_addr_i == 8'(W_VECTOR));
   assign eoi     = bus_wr_i && vec_hit;
   assign ack     = bus_rd_i && !bus_wr_i && vec_hit && win_any;

   vic_nest #(.LVL_W(PRIO_W), .LEVELS(LEVELS)) i_nest (
      .clk(clk), .rst_n(rst_n), .push_i(ack), .push_lvl_i(win_lvl),
      .pop_i(eoi), .thr_o(thr)
   );

   assign vector = win_any ? hand[win_idx] : dflt;
   assign fiq_o  = |fast;
   assign irq_o  = win_any;

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         8'(W_RAW):     bus_rdata_o[N_SRC-1:0] = src_req_i;
         8'(W_ENABLE):  bus_rdata_o[N_SRC-1:0] = en;
         8'(W_CLASS):   bus_rdata_o[N_SRC-1:0] = cls;
         8'(W_FSTAT):   bus_rdata_o[N_SRC-1:0] = fast;
         8'(W_NSTAT):   bus_rdata_o[N_SRC-1:0] = elig;
         8'(W_DEFAULT): bus_rdata_o = dflt;
         8'(W_VECTOR):  bus_rdata_o = vector;
         default: begin
            for (int i = 0; i < int'(N_SRC); i++) begin
               if (bus_addr_i == 8'(HAND_BASE + i)) bus_rdata_o = hand[i];
               if (bus_addr_i == 8'(PRIO_BASE + i)) bus_rdata_o[PRIO_W-1:0] = prio[i];
            end
         end
      endcase
   end

   // independent search for a source that should have beaten the winner
   logic better;
   always_comb begin
      better = 1'b0;
      for (int i = 0; i < int'(N_SRC); i++)
         if (norm[i] && ({1'b0, prio[i]} < thr) &&
             (prio[i] < win_lvl || (prio[i] == win_lvl && IDX_W'(i) < win_idx)))
            better = 1'b1;
   end

   // R5: no eligible source outranks the chosen one
   a_r5_best_wins: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !better);

   // R7: the chosen level lies strictly above the active mask
   a_r7_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ({1'b0, win_lvl} < thr));

   // R7: an acknowledge tightens the mask to the acknowledged level
   a_r7_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> thr == {1'b0, $past(win_lvl)});

   // R1: one cycle of reset leaves both outputs quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!irq_o && !fiq_o) || !$past(src_req_i != '0) || (en != '0));

   // R3: fast and normal classes never share a source
   a_r3_classes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (fast & elig) == '0);

endmodule

// File: tb/test_vic_top.sv
`timescale 1ns/1ps
module test_vic_top;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_req = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        fiq_o, irq_o;

   always #5 clk = ~clk;

   vic_top i_vic_top (
      .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .bus_rd_i(bus_rd),
      .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
      .bus_rdata_o(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
   );

   int checks = 0, errors = 0;

   // reference model
   logic [31:0] m_en = '0, m_cls = '0, m_def = '0;
   logic [3:0]  m_pr [N];
   logic [31:0] m_h  [N];
   logic [15:0] m_act = '0;

   function automatic int thr();
      for (int l = 0; l < 16; l++) if (m_act[l]) return l;
      return 16;
   endfunction

   function automatic logic [31:0] exp_nstat();
      logic [31:0] s = '0;
      for (int i = 0; i < N; i++)
         if (src_req[i] && m_en[i] && !m_cls[i] && int'(m_pr[i]) < thr()) s[i] = 1'b1;
      return s;
   endfunction

   function automatic int winner();
      int w = -1;
      logic [31:0] s = exp_nstat();
      for (int i = 0; i < N; i++)
         if (s[i] && (w < 0 || m_pr[i] < m_pr[w])) w = i;
      return w;
   endfunction

   function automatic logic [31:0] exp_vec();
      int w = winner();
      return (w >= 0) ? m_h[w] : m_def;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic peek(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      if (a == 8'd1) m_en = d;
      else if (a == 8'd2) m_cls = d;
      else if (a == 8'd5) m_def = d;
      else if (a == 8'd6) m_act = m_act & (m_act - 16'd1);
      else if (a >= 8'd64 && a < 8'd96) m_h[a - 8'd64] = d;
      else if (a >= 8'd128 && a < 8'd160) m_pr[a - 8'd128] = d[3:0];
   endtask

   task automatic ack(string tag);
      logic [31:0] d;
      int w;
      @(negedge clk);
      w = winner();
      bus_addr = 8'd6; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      chk(tag, d, exp_vec());
      @(posedge clk);
      #1;
      bus_rd = 1'b0;
      if (w >= 0) m_act[m_pr[w]] = 1'b1;
   endtask

   task automatic check_all(string tag);
      logic [31:0] d;
      @(negedge clk);
      #1;
      chk({tag, " irq_o (R4)"}, {31'd0, irq_o}, {31'd0, winner() >= 0});
      chk({tag, " fiq_o (R3)"}, {31'd0, fiq_o}, {31'd0, |(src_req & m_en & m_cls)});
      peek(8'd6, d); chk({tag, " vector (R6)"}, d, exp_vec());
      peek(8'd4, d); chk({tag, " normal status (R4)"}, d, exp_nstat());
      peek(8'd3, d); chk({tag, " fast status (R3)"}, d, src_req & m_en & m_cls);
      peek(8'd0, d); chk({tag, " raw status (R2)"}, d, src_req);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd2024));
      for (int i = 0; i < N; i++) begin m_pr[i] = 4'hF; m_h[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk); #1;
      chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
      chk("R1 fiq_o", {31'd0, fiq_o}, 32'd0);
      peek(8'd1, d); chk("R1 enable word", d, 32'd0);
      peek(8'd2, d); chk("R1 class word", d, 32'd0);
      peek(8'd6, d); chk("R1 vector", d, 32'd0);

      // program handlers and default
      for (int i = 0; i < N; i++) bus_write(8'(64 + i), 32'hA000_0000 | (32'(i) << 4));
      bus_write(8'd5, 32'hDEAD_0000);

      // R2: disabled sources are invisible at the outputs
      src_req = 32'h0000_0088;
      check_all("R2 disabled requests");

      // R9: write not visible before its edge
      @(negedge clk);
      bus_addr = 8'd1; bus_wdata = 32'h0000_0088; bus_wr = 1'b1;
      #1;
      chk("R9 irq_o before edge", {31'd0, irq_o}, 32'd0);
      @(posedge clk); #1; bus_wr = 1'b0; m_en = 32'h0000_0088;
      #1;
      chk("R9 irq_o after edge", {31'd0, irq_o}, 32'd1);

      // R5: equal level, lower index wins
      bus_write(8'd131, 32'd5);
      bus_write(8'd135, 32'd5);
      check_all("R5 tie");
      chk("R5 tie winner", exp_vec(), 32'hA000_0030);
      bus_write(8'd135, 32'd2);
      check_all("R5 more urgent level");

      // R7: acknowledge masks same and less urgent levels
      ack("R7 ack vector");
      check_all("R7 masked after ack");
      chk("R7 irq_o low", {31'd0, irq_o}, 32'd0);
      bus_write(8'd138, 32'd1);
      bus_write(8'd1, 32'h0000_0488);
      src_req = 32'h0000_0488;
      check_all("R7 more urgent still fires");
      ack("R7 nested ack");
      check_all("R7 two levels active");

      // R8: end of interrupt pops most urgent level only
      bus_write(8'd6, 32'h1234_5678);
      check_all("R8 after first eoi");
      bus_write(8'd6, 32'h0);
      check_all("R8 after second eoi");
      bus_write(8'd6, 32'h0);
      check_all("R8 eoi with none active");

      // R3: fast class
      bus_write(8'd2, 32'h0000_0400);
      check_all("R3 fast class");
      src_req = 32'h0;
      ack("R6 default when idle");
      check_all("R6 idle");

      // constrained random
      bus_write(8'd1, 32'hFFFF_FFFF);
      bus_write(8'd2, 32'h0000_0000);
      for (int it = 0; it < 400; it++) begin
         int op;
         @(negedge clk);
         src_req = $urandom & $urandom & $urandom;
         op = int'($urandom % 9);
         case (op)
            0: bus_write(8'd1, $urandom | $urandom);
            1: bus_write(8'd2, $urandom & $urandom & $urandom);
            2: bus_write(8'(128 + $urandom % N), $urandom % 16);
            3, 4: ack("R7 random ack");
            5: bus_write(8'd6, $urandom);
            6: bus_write(8'd5, $urandom);
            default: ;
         endcase
         check_all("random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule